// File: doc/BRIEF.md
# Timer Counter Flag Core

This block holds a free-running timer counter together with the event flags that surround it: one flag per timer channel, a counter wrap flag, and two pulse-accumulator flags. Other logic reports channel capture/compare events and accumulator edge/overflow events to it as one-cycle strobes; the block latches them into sticky flags and presents the flags and the counter value as outputs.

Software clears flags over a byte-addressed register bus with separate read and write strobes. Normally a flag clears when a 1 is written to its bit. When the fast-clear mode bit is set, an ordinary access to the data register that belongs to a flag also clears that flag, which saves the separate clear access. A freeze input, used while the chip is halted for debug, can stop the counter when a control bit asks for it; it never affects the accumulator flags.

The capture and compare datapaths and the accumulator counter live elsewhere; only the addresses of their byte registers are decoded here.

Top module: `tmr_flag_core`

## Requirements
- R1: After a synchronous reset the counter, every flag and every control bit read as zero.
- R2: The control register at address 0x06 holds the run bit in bit 0; while it is 1 the counter advances by one each clock, and while it is 0 the counter holds its value.
- R3: When the counter advances from its all-ones value it becomes zero and the wrap flag (bit 7 of address 0x0F) sets in the same clock.
- R4: With the freeze-stop bit (bit 1 of 0x06) set, the counter holds while freeze_in is high; with that bit clear, the counter keeps advancing while freeze_in is high.
- R5: Channel strobes set the channel flags (bit i of 0x0E for channel i), and the accumulator strobes set the accumulator flags (0x21 bit 1 for overflow, bit 0 for edge), also while the counter is frozen.
- R6: Writing 1 to a flag bit at 0x0E, 0x0F or 0x21 clears that flag; writing 0 to a bit leaves it unchanged.
- R7: If a flag's set strobe and a clear of that flag arrive in the same clock, the flag ends up set.
- R8: With the fast-clear bit (bit 2 of 0x06) set, a read or write of either byte of channel i's data pair (addresses 0x10+2i and 0x11+2i) clears channel flag i and no other flag.
- R9: With fast-clear set, a read or write of the counter bytes at 0x04 or 0x05 clears the wrap flag.
- R10: With fast-clear set, a read or write of the accumulator count bytes at 0x22 or 0x23 clears both accumulator flags.
- R11: With fast-clear clear, reads and writes of the channel data, counter and accumulator count addresses leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the current access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| freeze_in | input | 1 | Debug freeze indication |
| chan_evt | input | NCH | Per-channel capture/compare event strobes |
| pa_ovf_evt | input | 1 | Accumulator overflow strobe |
| pa_edge_evt | input | 1 | Accumulator input edge strobe |
| cnt_val | output | CNT_W | Counter value |
| chan_flags | output | NCH | Channel event flags |
| ovf_flag | output | 1 | Counter wrap flag |
| pa_flags | output | 2 | Accumulator flags, bit 1 overflow, bit 0 edge |

## Verification
The bench builds the block with an 8-bit counter and eight channels. The narrow counter brings the all-ones to zero wrap within a few hundred clocks, so the wrap flag and both of its clearing paths are exercised alongside the channel decode at its lowest and highest address pairs. With eight channels the full flag byte is in use, so a stray clear on a neighbouring channel shows up directly in the flag pattern.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [7:0] A_CNT_HI  = 8'h04;
  localparam logic [7:0] A_CNT_LO  = 8'h05;
  localparam logic [7:0] A_CTRL    = 8'h06;
  localparam logic [7:0] A_CHFLG   = 8'h0E;
  localparam logic [7:0] A_OVFLG   = 8'h0F;
  localparam logic [7:0] A_CHDAT   = 8'h10;
  localparam logic [7:0] A_PAFLG   = 8'h21;
  localparam logic [7:0] A_PACNT_H = 8'h22;
  localparam logic [7:0] A_PACNT_L = 8'h23;

  localparam int OVF_BIT     = 7;
  localparam int PA_OVF_BIT  = 1;
  localparam int PA_EDGE_BIT = 0;

  typedef struct packed {
    logic fast;
    logic fstop;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [2:0] bus_wbits,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (bus_wr && bus_addr == A_CTRL)
      ctrl_q <= ctrl_t'(bus_wbits);
  end

  assign ctrl_o = ctrl_q;

  assert_ctrl_hold_R2 : assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == A_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             fstop,
  input  logic             freeze_in,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             adv;

  assign adv = run && !(fstop && freeze_in);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (adv)
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = adv && (cnt_q == MAX);

  assert_hold_when_off_R2 : assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt_q));
  assert_step_one_R2 : assert property (@(posedge clk) disable iff (rst)
    (run && !freeze_in && cnt_q != MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_freeze_hold_R4 : assert property (@(posedge clk) disable iff (rst)
    (fstop && freeze_in) |=> $stable(cnt_q));
  assert_wrap_zero_R3 : assert property (@(posedge clk) disable iff (rst)
    (run && !freeze_in && cnt_q == MAX) |=> cnt_q == '0);
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= '0;
    else
      flags_q <= set_i | (flags_q & ~clr_i);
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_set_wins_R7 : assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flags_q[i]);
    assert_clear_R6 : assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !flags_q[i]);
    assert_sticky_R6 : assert property (@(posedge clk) disable iff (rst)
      (!clr_i[i] && !set_i[i]) |=> $stable(flags_q[i]));
  end
endmodule

// File: rtl/tmr_clear_decode.sv
module tmr_clear_decode
  import tmr_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic [7:0]     bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [7:0]     bus_wdata,
  input  logic           fast,
  output logic [NCH-1:0] ch_clr,
  output logic           ovf_clr,
  output logic [1:0]     pa_clr
);
  logic acc_fast;
  assign acc_fast = fast && (bus_wr || bus_rd);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [7:0] BASE = A_CHDAT + 8'(2 * i);
    logic hit;
    assign hit = (bus_addr & 8'hFE) == BASE;
    assign ch_clr[i] = (acc_fast && hit) ||
                       (bus_wr && bus_addr == A_CHFLG && bus_wdata[i]);
  end

  assign ovf_clr = (acc_fast && (bus_addr == A_CNT_HI || bus_addr == A_CNT_LO)) ||
                   (bus_wr && bus_addr == A_OVFLG && bus_wdata[OVF_BIT]);

  logic pa_hit;
  assign pa_hit = acc_fast && (bus_addr == A_PACNT_H || bus_addr == A_PACNT_L);

  assign pa_clr[PA_OVF_BIT]  = pa_hit ||
                               (bus_wr && bus_addr == A_PAFLG && bus_wdata[PA_OVF_BIT]);
  assign pa_clr[PA_EDGE_BIT] = pa_hit ||
                               (bus_wr && bus_addr == A_PAFLG && bus_wdata[PA_EDGE_BIT]);
endmodule

// File: rtl/tmr_flag_core.sv
module tmr_flag_core
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCH   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  input  logic             freeze_in,
  input  logic [NCH-1:0]   chan_evt,
  input  logic             pa_ovf_evt,
  input  logic             pa_edge_evt,
  output logic [CNT_W-1:0] cnt_val,
  output logic [NCH-1:0]   chan_flags,
  output logic             ovf_flag,
  output logic [1:0]       pa_flags
);
  ctrl_t          ctrl;
  logic           wrap;
  logic [NCH-1:0] ch_clr;
  logic           ovf_clr;
  logic [1:0]     pa_clr;
  logic [1:0]     pa_set;

  tmr_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wbits (bus_wdata[2:0]),
    .ctrl_o    (ctrl)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .run       (ctrl.run),
    .fstop     (ctrl.fstop),
    .freeze_in (freeze_in),
    .cnt_o     (cnt_val),
    .wrap_o    (wrap)
  );

  tmr_clear_decode #(.NCH(NCH)) u_dec (
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .fast      (ctrl.fast),
    .ch_clr    (ch_clr),
    .ovf_clr   (ovf_clr),
    .pa_clr    (pa_clr)
  );

  tmr_flag_bank #(.W(NCH)) u_chflg (
    .clk     (clk),
    .rst     (rst),
    .set_i   (chan_evt),
    .clr_i   (ch_clr),
    .flags_o (chan_flags)
  );

  tmr_flag_bank #(.W(1)) u_ovflg (
    .clk     (clk),
    .rst     (rst),
    .set_i   (wrap),
    .clr_i   (ovf_clr),
    .flags_o (ovf_flag)
  );

  always_comb begin
    pa_set              = '0;
    pa_set[PA_OVF_BIT]  = pa_ovf_evt;
    pa_set[PA_EDGE_BIT] = pa_edge_evt;
  end

  tmr_flag_bank #(.W(2)) u_paflg (
    .clk     (clk),
    .rst     (rst),
    .set_i   (pa_set),
    .clr_i   (pa_clr),
    .flags_o (pa_flags)
  );

  assert_wrap_sets_flag_R3 : assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl.run) && !$past(freeze_in) && cnt_val == '0 && $past(cnt_val) == '1) |-> ovf_flag);
  assert_no_fast_clear_R11 : assert property (@(posedge clk) disable iff (rst)
    (!ctrl.fast && !bus_wr) |-> (ch_clr == '0 && !ovf_clr && pa_clr == '0));
  assert_pa_free_in_freeze_R5 : assert property (@(posedge clk) disable iff (rst)
    (freeze_in && pa_ovf_evt && pa_edge_evt) |=> pa_flags == 2'b11);
endmodule

// File: tb/tmr_flag_core_tb.sv
module tmr_flag_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int NCH   = 8;
  localparam int MASK  = (1 << CNT_W) - 1;

  localparam int SEL_CNT = 0;
  localparam int SEL_CH  = 1;
  localparam int SEL_OVF = 2;
  localparam int SEL_PA  = 3;

  typedef struct {
    int    sel;
    int    exp;
    string req;
  } item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       bus_addr = '0;
  logic             bus_wr = 1'b0;
  logic             bus_rd = 1'b0;
  logic [7:0]       bus_wdata = '0;
  logic             freeze_in = 1'b0;
  logic [NCH-1:0]   chan_evt = '0;
  logic             pa_ovf_evt = 1'b0;
  logic             pa_edge_evt = 1'b0;
  logic [CNT_W-1:0] cnt_val;
  logic [NCH-1:0]   chan_flags;
  logic             ovf_flag;
  logic [1:0]       pa_flags;

  item_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_flag_core #(.CNT_W(CNT_W), .NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .freeze_in(freeze_in), .chan_evt(chan_evt),
    .pa_ovf_evt(pa_ovf_evt), .pa_edge_evt(pa_edge_evt), .cnt_val(cnt_val),
    .chan_flags(chan_flags), .ovf_flag(ovf_flag), .pa_flags(pa_flags)
  );

  // Monitor: pops expected items and compares against the ports.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.sel)
        SEL_CNT: act = int'(cnt_val);
        SEL_CH:  act = int'(chan_flags);
        SEL_OVF: act = int'(ovf_flag);
        default: act = int'(pa_flags);
      endcase
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s sel=%0d actual=0x%0h expected=0x%0h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_item(input int sel, input int exp, input string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic access(input logic [7:0] a, input logic w, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wr = w; bus_rd = !w; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] ch, input logic po, input logic pe);
    @(posedge clk); #1;
    chan_evt = ch; pa_ovf_evt = po; pa_edge_evt = pe;
    @(posedge clk); #1;
    chan_evt = '0; pa_ovf_evt = 1'b0; pa_edge_evt = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  initial begin
    int c;
    cycles(3);
    rst = 1'b0;
    // R1 reset state
    expect_item(SEL_CNT, 0, "R1 counter");
    expect_item(SEL_CH, 0, "R1 chan flags");
    expect_item(SEL_OVF, 0, "R1 wrap flag");
    expect_item(SEL_PA, 0, "R1 pa flags");
    cycles(5);
    expect_item(SEL_CNT, 0, "R2 run off holds");

    // R2 run
    access(8'h06, 1'b1, 8'h01);
    expect_item(SEL_CNT, 0, "R2 start");
    cycles(5);
    expect_item(SEL_CNT, 5, "R2 five steps");

    // R4 freeze with stop bit
    access(8'h06, 1'b1, 8'h03);
    freeze_in = 1'b1;
    cycles(1);
    c = int'(cnt_val);
    cycles(4);
    expect_item(SEL_CNT, c, "R4 frozen");
    pulse('0, 1'b1, 1'b1);
    expect_item(SEL_PA, 3, "R5 pa sets in freeze");
    expect_item(SEL_CNT, c, "R4 still frozen");
    // R4 freeze without stop bit
    access(8'h06, 1'b1, 8'h01);
    c = int'(cnt_val);
    cycles(3);
    expect_item(SEL_CNT, (c + 3) & MASK, "R4 runs in freeze");
    freeze_in = 1'b0;

    // R5 channel flags, R11 fast off
    pulse(8'hFF, 1'b0, 1'b0);
    expect_item(SEL_CH, 8'hFF, "R5 chan set");
    access(8'h10, 1'b0, 8'h00);
    expect_item(SEL_CH, 8'hFF, "R11 read ch0 no clear");
    access(8'h13, 1'b1, 8'hFF);
    expect_item(SEL_CH, 8'hFF, "R11 write ch1 no clear");
    access(8'h22, 1'b0, 8'h00);
    expect_item(SEL_PA, 3, "R11 pa count no clear");

    // R6 write-one clear
    access(8'h0E, 1'b1, 8'h05);
    expect_item(SEL_CH, 8'hFA, "R6 w1c chan");
    access(8'h0E, 1'b1, 8'h00);
    expect_item(SEL_CH, 8'hFA, "R6 w0 no effect");
    access(8'h21, 1'b1, 8'h01);
    expect_item(SEL_PA, 2, "R6 w1c pa edge");

    // R7 set wins
    @(posedge clk); #1;
    chan_evt = 8'h02; bus_addr = 8'h0E; bus_wr = 1'b1; bus_wdata = 8'h02;
    @(posedge clk); #1;
    chan_evt = '0; bus_wr = 1'b0;
    expect_item(SEL_CH, 8'hFA, "R7 set wins");

    // R8 fast clear of channels
    access(8'h06, 1'b1, 8'h05);
    access(8'h13, 1'b0, 8'h00);
    expect_item(SEL_CH, 8'hF8, "R8 read ch1 high");
    access(8'h1E, 1'b1, 8'h55);
    expect_item(SEL_CH, 8'h78, "R8 write ch7 low");
    access(8'h16, 1'b0, 8'h00);
    expect_item(SEL_CH, 8'h70, "R8 read ch3 low");

    // R10 fast clear of accumulator flags
    pulse('0, 1'b1, 1'b1);
    expect_item(SEL_PA, 3, "R5 pa set again");
    access(8'h23, 1'b0, 8'h00);
    expect_item(SEL_PA, 0, "R10 pa cleared");

    // R3 wrap
    access(8'h0F, 1'b1, 8'h80);
    expect_item(SEL_OVF, 0, "R6 w1c wrap");
    while (int'(cnt_val) != MASK) cycles(1);
    expect_item(SEL_OVF, 0, "R3 before wrap");
    cycles(1);
    expect_item(SEL_CNT, 0, "R3 wrapped to zero");
    expect_item(SEL_OVF, 1, "R3 wrap flag set");

    // R11 / R6 / R9 on the wrap flag
    access(8'h06, 1'b1, 8'h01);
    access(8'h05, 1'b0, 8'h00);
    expect_item(SEL_OVF, 1, "R11 counter read no clear");
    access(8'h0F, 1'b1, 8'h00);
    expect_item(SEL_OVF, 1, "R6 wrap w0 no effect");
    access(8'h06, 1'b1, 8'h05);
    access(8'h04, 1'b1, 8'h00);
    expect_item(SEL_OVF, 0, "R9 counter write clears");
    expect_item(SEL_CH, 8'h70, "R9 chan untouched");

    cycles(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    done = 1'b1;
    $finish;
  end

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule